// File: doc/BRIEF.md
# Accumulator Subtract Unit with Condition Flags

This block is the subtract datapath of a fixed-point signal-processing arithmetic unit. It holds two 56-bit accumulators and four 24-bit operand registers. Each accumulator has an 8-bit guard field in bits 55:48, an upper 24-bit word in bits 47:24 and a lower 24-bit word in bits 23:0. The operand registers can be used alone, as 24-bit words, or in pairs that form a 48-bit long operand. A one-cycle start strobe comes with a 4-bit select code. The code names a source and a destination accumulator. The source is aligned as a two's-complement fraction, subtracted from the destination, and the difference is written back.

Every subtract also updates a set of condition flags: sign, zero, borrow, overflow, guard-in-use, unnormalized, and a sticky limit flag. The limit flag stays set until a dedicated clear input is pulsed. Registers are loaded through a simple write port. The accumulators and the flags can always be read at the outputs. A start with a reserved select code changes nothing and is reported on an error pulse.

Top module: `acc_sub_unit`

## Requirements
- R1: While `rst_n` is low, both accumulators, all four operand registers, all flags, `done` and `err` are zero.
- R2: When `ld_en` is high and `go` is low, the next edge loads the register chosen by `ld_sel`. The codes are 0 = word X0, 1 = word X1, 2 = word Y0, 3 = word Y1, 4 = accumulator A and 5 = accumulator B. Word registers take `ld_data[23:0]` and accumulators take all 56 bits. Codes 6 and 7 have no effect, loads never change the flags, and `ld_en` is ignored while `go` is high.
- R3: In `sel`, bit 0 picks the destination (0 = A, 1 = B). Bits 3:1 pick the source: 1 = the other accumulator, 2 = long X1:X0, 3 = long Y1:Y0, 4 = X0, 5 = Y0, 6 = X1, 7 = Y1. The accumulator that is not the destination is left unchanged.
- R4: A 24-bit word source is placed in bits 47:24 with zeros in bits 23:0, and is sign-extended from bit 47 into bits 55:48.
- R5: A long source has its high word in bits 47:24 and its low word in bits 23:0, and is sign-extended from bit 47. An accumulator source is used unchanged.
- R6: A strobe of `go` with a valid code writes destination minus source, modulo 2^56, into the destination on the same edge that samples `go`. `done` is high for exactly the following cycle.
- R7: `flags[3]` (N) equals bit 55 of the result. `flags[2]` (Z) is set when all 56 result bits are zero.
- R8: `flags[0]` (C) is set when the subtract borrows out of bit 55, that is, when the destination is less than the source taken as unsigned numbers. `flags[1]` (V) is set when the signed 56-bit difference does not fit in 56 bits.
- R9: `flags[5]` (E) is set when result bits 55:47 are not all equal. `flags[4]` (U) is set when result bits 47 and 46 are equal.
- R10: `flags[6]` (L) is set by any subtract that sets V. It is cleared only by `clr_limit`, and a set in the same cycle as a clear wins.
- R11: A `go` strobe with `sel[3:1]` = 0 leaves both accumulators and flags 5:0 unchanged. `err` is high for the following cycle and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Register to load |
| ld_data | input | 56 | Load data |
| go | input | 1 | Start a subtract |
| sel | input | 4 | Source and destination select |
| clr_limit | input | 1 | Clear the sticky limit flag |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| flags | output | 7 | {L, E, U, N, Z, V, C} |
| done | output | 1 | A valid subtract completed |
| err | output | 1 | A strobe with a reserved code was rejected |

## Verification
The assertions assume `go` is a clean level that is sampled once per edge, with the select code stable at that edge. They also assume that nothing but a subtract writes the accumulators while `go` is high. The design enforces the second point by dropping loads during a strobe, and the bench exercises that case directly. The random stimulus drives inputs only on falling edges. Random draws cover the reserved select codes, clears that coincide with strobes, and extreme operand values, so that overflow, borrow and guard-field flags are all reached within the legal input space.

// File: rtl/acs_pkg.sv
package acs_pkg;
  parameter int unsigned WORD_W = 24;
  parameter int unsigned EXT_W  = 8;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_OTHER = 3'd1,
    SRC_XL    = 3'd2,
    SRC_YL    = 3'd3,
    SRC_X0    = 3'd4,
    SRC_Y0    = 3'd5,
    SRC_X1    = 3'd6,
    SRC_Y1    = 3'd7
  } src_code_e;

  typedef enum logic [2:0] {
    LD_X0 = 3'd0,
    LD_X1 = 3'd1,
    LD_Y0 = 3'd2,
    LD_Y1 = 3'd3,
    LD_A  = 3'd4,
    LD_B  = 3'd5
  } ld_code_e;

  // first member is the most significant bit
  typedef struct packed {
    logic l;
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/acs_operand_mux.sv
module acs_operand_mux #(
  parameter int unsigned WORD_W = acs_pkg::WORD_W,
  parameter int unsigned EXT_W  = acs_pkg::EXT_W
) (
  input  logic [3:0]                  sel,
  input  logic [WORD_W-1:0]           x0,
  input  logic [WORD_W-1:0]           x1,
  input  logic [WORD_W-1:0]           y0,
  input  logic [WORD_W-1:0]           y1,
  input  logic [EXT_W+2*WORD_W-1:0]   acc_a,
  input  logic [EXT_W+2*WORD_W-1:0]   acc_b,
  output logic [EXT_W+2*WORD_W-1:0]   src_al,
  output logic                        sel_ok
);
  import acs_pkg::*;
  localparam int unsigned ACC_W = EXT_W + 2 * WORD_W;

  // word as a fraction: upper word position, zero low word, guard = sign
  function automatic logic [ACC_W-1:0] word_frac(input logic [WORD_W-1:0] w);
    return {{EXT_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
  endfunction

  function automatic logic [ACC_W-1:0] long_frac(input logic [WORD_W-1:0] hi,
                                                 input logic [WORD_W-1:0] lo);
    return {{EXT_W{hi[WORD_W-1]}}, hi, lo};
  endfunction

  src_code_e code;
  assign code   = src_code_e'(sel[3:1]);
  assign sel_ok = (code != SRC_NONE);

  always_comb begin
    unique case (code)
      SRC_OTHER: src_al = sel[0] ? acc_a : acc_b;
      SRC_XL:    src_al = long_frac(x1, x0);
      SRC_YL:    src_al = long_frac(y1, y0);
      SRC_X0:    src_al = word_frac(x0);
      SRC_Y0:    src_al = word_frac(y0);
      SRC_X1:    src_al = word_frac(x1);
      SRC_Y1:    src_al = word_frac(y1);
      default:   src_al = '0;
    endcase
  end
endmodule

// File: rtl/acs_sub_core.sv
module acs_sub_core #(
  parameter int unsigned WORD_W = acs_pkg::WORD_W,
  parameter int unsigned EXT_W  = acs_pkg::EXT_W
) (
  input  logic [EXT_W+2*WORD_W-1:0] dst,
  input  logic [EXT_W+2*WORD_W-1:0] src,
  output logic [EXT_W+2*WORD_W-1:0] res,
  output acs_pkg::ccr_t             fl
);
  import acs_pkg::*;
  localparam int unsigned ACC_W = EXT_W + 2 * WORD_W;
  localparam int unsigned MSB   = ACC_W - 1;
  localparam int unsigned FRAC  = 2 * WORD_W - 1;   // fraction sign bit

  function automatic logic guard_used(input logic [ACC_W-1:0] r);
    logic [EXT_W:0] top;
    top = r[MSB:FRAC];
    return !((&top) || !(|top));
  endfunction

  function automatic logic unnorm(input logic [ACC_W-1:0] r);
    return r[FRAC] == r[FRAC-1];
  endfunction

  logic [ACC_W:0] wide;
  assign wide = {1'b0, dst} - {1'b0, src};
  assign res  = wide[MSB:0];

  always_comb begin
    fl   = '0;
    fl.c = wide[ACC_W];
    fl.v = (dst[MSB] != src[MSB]) && (res[MSB] != dst[MSB]);
    fl.n = res[MSB];
    fl.z = (res == '0);
    fl.e = guard_used(res);
    fl.u = unnorm(res);
    fl.l = fl.v;
  end
endmodule

// File: rtl/acc_sub_unit.sv
module acc_sub_unit #(
  parameter int unsigned WORD_W = acs_pkg::WORD_W,
  parameter int unsigned EXT_W  = acs_pkg::EXT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [2:0]                ld_sel,
  input  logic [EXT_W+2*WORD_W-1:0] ld_data,
  input  logic                      go,
  input  logic [3:0]                sel,
  input  logic                      clr_limit,
  output logic [EXT_W+2*WORD_W-1:0] acc_a,
  output logic [EXT_W+2*WORD_W-1:0] acc_b,
  output logic [6:0]                flags,
  output logic                      done,
  output logic                      err
);
  import acs_pkg::*;
  localparam int unsigned ACC_W = EXT_W + 2 * WORD_W;

  logic [WORD_W-1:0] x0_q, x1_q, y0_q, y1_q;
  logic [ACC_W-1:0]  a_q, b_q;
  ccr_t              ccr_q;
  logic              done_q, err_q;

  // named internal events
  logic [ACC_W-1:0] src_al, dst_val, res_val;
  logic             sel_ok, op_fire, op_bad, ld_take;
  ccr_t             fl_nx;

  acs_operand_mux #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_mux (
    .sel(sel), .x0(x0_q), .x1(x1_q), .y0(y0_q), .y1(y1_q),
    .acc_a(a_q), .acc_b(b_q), .src_al(src_al), .sel_ok(sel_ok)
  );

  assign dst_val = sel[0] ? b_q : a_q;

  acs_sub_core #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_core (
    .dst(dst_val), .src(src_al), .res(res_val), .fl(fl_nx)
  );

  assign op_fire = go && sel_ok;
  assign op_bad  = go && !sel_ok;
  assign ld_take = ld_en && !go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x0_q <= '0; x1_q <= '0; y0_q <= '0; y1_q <= '0;
      a_q <= '0; b_q <= '0; ccr_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= op_fire;
      err_q  <= op_bad;
      if (ld_take) begin
        case (ld_sel)
          LD_X0:   x0_q <= ld_data[WORD_W-1:0];
          LD_X1:   x1_q <= ld_data[WORD_W-1:0];
          LD_Y0:   y0_q <= ld_data[WORD_W-1:0];
          LD_Y1:   y1_q <= ld_data[WORD_W-1:0];
          LD_A:    a_q  <= ld_data;
          LD_B:    b_q  <= ld_data;
          default: ;
        endcase
      end
      if (op_fire) begin
        if (sel[0]) b_q <= res_val;
        else        a_q <= res_val;
        ccr_q.e <= fl_nx.e;
        ccr_q.u <= fl_nx.u;
        ccr_q.n <= fl_nx.n;
        ccr_q.z <= fl_nx.z;
        ccr_q.v <= fl_nx.v;
        ccr_q.c <= fl_nx.c;
      end
      ccr_q.l <= (ccr_q.l && !clr_limit) || (op_fire && fl_nx.v);
    end
  end

  assign acc_a = a_q;
  assign acc_b = b_q;
  assign flags = ccr_q;
  assign done  = done_q;
  assign err   = err_q;

  // R6: written value is the difference of the operands seen at the strobe
  a_r6_difference: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> (($past(sel[0]) ? b_q : a_q) == $past(dst_val) - $past(src_al)));

  // R7: zero and sign flags follow the stored destination
  a_r7_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ccr_q.z == (($past(sel[0]) ? b_q : a_q) == '0)) &&
               (ccr_q.n == ($past(sel[0]) ? b_q[ACC_W-1] : a_q[ACC_W-1])));

  // R8: borrow equals unsigned compare of the operands
  a_r8_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> (ccr_q.c == ($past(dst_val) < $past(src_al))));

  // R10: limit flag holds until cleared
  a_r10_limit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_q.l && !clr_limit) |=> ccr_q.l);

  // R11: rejected strobe leaves state alone and reports
  a_r11_reject: assert property (@(posedge clk) disable iff (!rst_n)
    op_bad |=> $stable(a_q) && $stable(b_q) && $stable(flags[5:0]) && err_q && !done_q);
endmodule

// File: tb/acc_sub_unit_test.sv
`timescale 1ns/1ps
module acc_sub_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [55:0] ld_data = '0;
  logic        go = 1'b0;
  logic [3:0]  sel = '0;
  logic        clr_limit = 1'b0;
  logic [55:0] acc_a, acc_b;
  logic [6:0]  flags;
  logic        done, err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [23:0] m_x0, m_x1, m_y0, m_y1;
  logic [55:0] m_a, m_b;
  logic [6:0]  m_fl;

  always #10 clk = ~clk;

  acc_sub_unit uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .go(go), .sel(sel), .clr_limit(clr_limit), .acc_a(acc_a), .acc_b(acc_b),
    .flags(flags), .done(done), .err(err)
  );

  task automatic chk(input string tag, input string what, input logic [55:0] act,
                     input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [55:0] frac_word(input logic [23:0] w);
    logic signed [55:0] s;
    s = $signed({w, 24'h0});       // sign-extended 48-bit fraction
    return s;
  endfunction

  function automatic logic [55:0] frac_long(input logic [23:0] h, input logic [23:0] l);
    logic signed [55:0] s;
    s = $signed({h, l});
    return s;
  endfunction

  function automatic logic [55:0] ref_src(input logic [3:0] s);
    case (s[3:1])
      3'd1: return s[0] ? m_a : m_b;
      3'd2: return frac_long(m_x1, m_x0);
      3'd3: return frac_long(m_y1, m_y0);
      3'd4: return frac_word(m_x0);
      3'd5: return frac_word(m_y0);
      3'd6: return frac_word(m_x1);
      default: return frac_word(m_y1);
    endcase
  endfunction

  // one cycle: drive at falling edge, update model, check at next falling edge
  task automatic step(input bit g, input logic [3:0] s, input bit clr, input bit le,
                      input logic [2:0] ls, input logic [55:0] ld);
    bit valid, e_done, e_err, ov;
    logic [55:0] src, dst, res;
    logic signed [56:0] dif;
    logic signed [55:0] sh;
    string tag;
    @(negedge clk);
    go = g; sel = s; clr_limit = clr; ld_en = le; ld_sel = ls; ld_data = ld;
    valid = g && (s[3:1] != 3'd0);
    ov = 1'b0;
    if (valid) begin
      src = ref_src(s);
      dst = s[0] ? m_b : m_a;
      dif = $signed({dst[55], dst}) - $signed({src[55], src});
      res = dif[55:0];
      ov  = (dif > 57'sh0_7FFF_FFFF_FFFF_FF) || (dif < -57'sh0_8000_0000_0000_00);
      sh  = $signed(res) >>> 47;
      m_fl[5] = (sh != 0) && (sh != -1);
      m_fl[4] = ~(res[47] ^ res[46]);
      m_fl[3] = res[55];
      m_fl[2] = (res == 56'h0);
      m_fl[1] = ov;
      m_fl[0] = (dst < src);
      if (s[0]) m_b = res; else m_a = res;
    end else if (le && !g) begin
      case (ls)
        3'd0: m_x0 = ld[23:0];
        3'd1: m_x1 = ld[23:0];
        3'd2: m_y0 = ld[23:0];
        3'd3: m_y1 = ld[23:0];
        3'd4: m_a = ld;
        3'd5: m_b = ld;
        default: ;
      endcase
    end
    m_fl[6] = (m_fl[6] && !clr) || (valid && ov);
    e_done = valid;
    e_err  = g && !valid;
    @(negedge clk);
    go = 1'b0; ld_en = 1'b0; clr_limit = 1'b0;
    if (!g) tag = "R2";
    else if (!valid) tag = "R11";
    else if (s[3]) tag = "R4";
    else if (s[2]) tag = "R5";
    else tag = "R6";
    if (valid && s[0]) begin
      chk(tag, "acc_b", acc_b, m_b);
      chk("R3", "acc_a untouched", acc_a, m_a);
    end else if (valid) begin
      chk(tag, "acc_a", acc_a, m_a);
      chk("R3", "acc_b untouched", acc_b, m_b);
    end else begin
      chk(tag, "acc_a", acc_a, m_a);
      chk(tag, "acc_b", acc_b, m_b);
    end
    chk("R7", "N,Z", {54'h0, flags[3:2]}, {54'h0, m_fl[3:2]});
    chk("R8", "V,C", {54'h0, flags[1:0]}, {54'h0, m_fl[1:0]});
    chk("R9", "E,U", {54'h0, flags[5:4]}, {54'h0, m_fl[5:4]});
    chk("R10", "L", {55'h0, flags[6]}, {55'h0, m_fl[6]});
    chk("R6", "done", {55'h0, done}, {55'h0, e_done});
    chk("R11", "err", {55'h0, err}, {55'h0, e_err});
  endtask

  task automatic load(input logic [2:0] ls, input logic [55:0] d);
    step(1'b0, 4'h0, 1'b0, 1'b1, ls, d);
  endtask

  function automatic logic [55:0] rnd56();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 6)
      0: return 56'h7F_FFFF_FFFF_FFFF;
      1: return 56'h80_0000_0000_0000;
      2: return '0;
      default: return r[55:0];
    endcase
  endfunction

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0C1A);
    m_x0 = '0; m_x1 = '0; m_y0 = '0; m_y1 = '0; m_a = '0; m_b = '0; m_fl = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "acc_a", acc_a, 56'h0);
    chk("R1", "acc_b", acc_b, 56'h0);
    chk("R1", "flags", {49'h0, flags}, 56'h0);
    chk("R1", "done/err", {54'h0, done, err}, 56'h0);
    rst_n = 1'b1;

    // R4: worked example, word X1 from A
    load(3'd4, 56'h00_000058_242424);
    load(3'd1, 56'h000003);
    step(1'b1, 4'b1100, 1'b0, 1'b0, 3'd0, '0);
    chk("R4", "example result", acc_a, 56'h00_000055_242424);
    // R7: zero result via other accumulator
    load(3'd5, acc_a);
    step(1'b1, 4'b0010, 1'b0, 1'b0, 3'd0, '0);
    // R8/R10: overflow and borrow: max positive minus -1
    load(3'd4, 56'h7F_FFFF_FFFF_FFFF);
    load(3'd5, 56'hFF_FFFF_FFFF_FFFF);
    step(1'b1, 4'b0010, 1'b0, 1'b0, 3'd0, '0);
    // R10: sticky across a clean op
    load(3'd0, 56'h000001);
    step(1'b1, 4'b1001, 1'b0, 1'b0, 3'd0, '0);
    // R10: clear alone
    step(1'b0, 4'h0, 1'b1, 1'b0, 3'd0, '0);
    // R5: long sources into both destinations
    load(3'd2, 56'h123456); load(3'd3, 56'h800000);
    step(1'b1, 4'b0110, 1'b0, 1'b0, 3'd0, '0);
    step(1'b1, 4'b0101, 1'b0, 1'b0, 3'd0, '0);
    // R11: reserved codes
    step(1'b1, 4'b0000, 1'b0, 1'b0, 3'd0, '0);
    step(1'b1, 4'b0001, 1'b0, 1'b0, 3'd0, '0);
    // R2: load ignored during a strobe, unused load codes
    step(1'b1, 4'b1110, 1'b0, 1'b1, 3'd4, 56'hAA_AAAA_AAAA_AAAA);
    load(3'd6, 56'h11_1111_1111_1111);
    load(3'd7, 56'h22_2222_2222_2222);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] s;
      if ($urandom % 3 == 0) load(3'($urandom % 8), rnd56());
      s = 4'($urandom);
      step(1'b1, s, ($urandom % 6) == 0, 1'b0, 3'd0, '0);
      if ($urandom % 10 == 0) step(1'b0, 4'h0, 1'b1, 1'b0, 3'd0, '0);
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule